// File: doc/BRIEF.md
# Frame-Based I/Q Automatic Gain Controller

This block sits in a receive path and scales a stream of 16-bit signed I/Q sample pairs by a power of two. The scale factor is a 4-bit sign-magnitude shift code. With the direction bit clear, the block shifts left (amplifies) and saturates. With the direction bit set, it shifts right arithmetically (attenuates). Each shifted pair is registered and leaves the block one cycle after it arrives.

While a frame streams through, the block measures two things:
- the largest pre-gain magnitude seen on either lane;
- how many sample pairs clipped after the gain was applied.

A frame-end strobe closes the frame. On that strobe the block latches both measurements to status outputs. When the loop is enabled, it also moves its stored signed gain:
- It drops the gain at once by an attack step when anything clipped.
- It raises the gain by a decay step only after a configurable number of consecutive weak frames.
- It holds the gain when the peak sits at or above the target.

Control software drives the configuration inputs directly. Typical settings are target 200, attack 1, decay 1 and holdoff 4.

Top module: `iq_agc`

## Requirements
- R1: The gain code selects the shift. Bit 3 = 0 shifts left by bits [2:0]. Bit 3 = 1 shifts right arithmetically by bits [2:0], so the result is rounded toward minus infinity. An amount of 0 passes the sample through unchanged.
- R2: A shifted lane value above +32767 is replaced by +32767. A value below -32768 is replaced by -32768.
- R3: The stored gain always lies in -7..+7. Every step result is clamped to that range. A negative gain g is coded as {1, |g|} and a non-negative gain as {0, g}.
- R4: A sample pair counts as one clip if I, Q or both saturate. The per-frame clip count stops at 255.
- R5: The frame peak is the maximum over the frame of max(|I|, |Q|), taken before the gain. The magnitude of -32768 is taken as 32767. The reported peak is bits [14:7] of this 15-bit magnitude.
- R6: In the cycle after a frame-end strobe, stat_valid is high for exactly one cycle, and stat_peak and stat_sat show that frame's values. A sample presented together with the strobe belongs to the closing frame. The accumulators restart from zero for the next frame. A frame with no samples reports 0 and 0.
- R7: At a frame end with the loop enabled and a clip count above zero, the gain falls by cfg_attack and the holdoff counter is reloaded from cfg_holdoff.
- R8: At a frame end with the loop enabled, no clips, and a peak below cfg_target, two cases apply. If the holdoff counter is zero, the gain rises by cfg_decay. Otherwise the counter decrements and the gain is unchanged.
- R9: At a frame end with the loop enabled, no clips, and a peak of at least cfg_target, the gain is kept and the holdoff counter is reloaded.
- R10: On the first cycle cfg_enable is seen high after being low (or after reset), the gain becomes 0 and the holdoff counter loads cfg_holdoff. This takes priority over a coincident frame end.
- R11: While cfg_enable is low, the stored gain does not change and keeps being applied to the stream.
- R12: out_valid follows in_valid by one cycle. The gain code changes only on the edge that samples a frame end or an enable rise. A new gain applies from the first sample after that edge.
- R13: After reset, out_valid and stat_valid are low, and gain_code, stat_peak and stat_sat are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample pair present |
| in_frame_end | input | 1 | Closes the current frame (may coincide with a sample) |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| cfg_enable | input | 1 | Closed-loop gain updates allowed |
| cfg_target | input | 8 | Peak target on the 8-bit peak scale |
| cfg_attack | input | 4 | Gain decrease step on clipping |
| cfg_decay | input | 4 | Gain increase step on weak frames |
| cfg_holdoff | input | 4 | Weak frames to wait before a gain increase |
| out_valid | output | 1 | Shifted pair present |
| out_i | output | 16 | Shifted, saturated in-phase sample |
| out_q | output | 16 | Shifted, saturated quadrature sample |
| gain_code | output | 4 | Sign-magnitude shift code in use |
| stat_valid | output | 1 | One-cycle pulse: frame status updated |
| stat_peak | output | 8 | Last frame's pre-gain peak, bits [14:7] |
| stat_sat | output | 8 | Last frame's clipped-pair count, capped at 255 |

## Verification
The stimulus mixes several frame types:
- small tones that should be held back by holdoff;
- a mid-level tone that drives two successive gain rises;
- large tones that clip under amplification and trigger an attack;
- a full-scale negative sample;
- a frame that sits above the target;
- a frame with no samples.

Together these separate the four update branches (attack, decay, holdoff countdown, hold with reload) and show the cycle on which each takes effect.

Long frames of clipping pairs at maximum gain exercise the 255 cap. Extreme attack and decay steps exercise the clamps at +7 and -7. Negative and positive samples under attenuation show that the right shift floors instead of truncating toward zero.

Frames sent with the loop disabled, and the following enable rise, show that the gain is frozen and then reset with a fresh holdoff.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
// agc_pkg: shared widths and gain-code helpers for the frame AGC.
// Assumes the gain code is sign-magnitude with the direction in its MSB.
package agc_pkg;

    localparam int unsigned SAMPLE_W = 16;  // I/Q lane width
    localparam int unsigned CODE_W   = 4;   // shift code width
    localparam int unsigned STEP_W   = 4;   // attack/decay/holdoff width
    localparam int unsigned STAT_W   = 8;   // peak/target/count width
    localparam int unsigned LANES    = 2;   // I and Q

    // Map a signed gain (already clamped) to the sign-magnitude code.
    function automatic logic [CODE_W-1:0] gain_to_code(input logic signed [CODE_W-1:0] g);
        logic [CODE_W-1:0] mag;
        mag = g[CODE_W-1] ? CODE_W'(-g) : CODE_W'(g);
        return {g[CODE_W-1], mag[CODE_W-2:0]};
    endfunction

endpackage

// File: rtl/agc_shifter.sv
`timescale 1ns/1ps
// agc_shifter: applies the power-of-two gain code to each lane, saturates
// to the signed lane range and registers the result (one cycle latency).
// Assumes the code is stable while a sample is presented.  Also reports,
// combinationally, whether the presented pair clips on any lane.
module agc_shifter
    import agc_pkg::*;
#(
    parameter int unsigned DATA_W = SAMPLE_W,
    parameter int unsigned CW     = CODE_W,
    parameter int unsigned NLANE  = LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NLANE-1:0][DATA_W-1:0]  in_lane,
    input  logic [CW-1:0]                 code,
    output logic                          out_valid,
    output logic [NLANE-1:0][DATA_W-1:0]  out_lane,
    output logic                          pair_clip
);

    localparam int unsigned AMT_W  = CW - 1;
    localparam int unsigned MAXAMT = (1 << AMT_W) - 1;
    localparam int unsigned EXT_W  = DATA_W + MAXAMT + 1;
    localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((1 << (DATA_W-1)) - 1);
    localparam logic signed [EXT_W-1:0] NEG_LIM = -EXT_W'(1 << (DATA_W-1));

    logic              attenuate;
    logic [AMT_W-1:0]  amount;
    logic [NLANE-1:0]  lane_clip;
    logic [NLANE-1:0][DATA_W-1:0] lane_res;

    assign attenuate = code[CW-1];
    assign amount    = code[AMT_W-1:0];

    // One saturating shifter per lane.
    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
        logic signed [EXT_W-1:0] ext;
        logic signed [EXT_W-1:0] shl;
        logic signed [DATA_W-1:0] shr;

        // Purpose: compute both shift directions and pick/saturate.
        always_comb begin
            ext = EXT_W'($signed(in_lane[ln]));
            shl = ext <<< amount;
            shr = $signed(in_lane[ln]) >>> amount;
            lane_clip[ln] = 1'b0;
            if (attenuate) begin
                lane_res[ln] = shr;
            end else if (shl > POS_LIM) begin
                lane_res[ln]  = POS_LIM[DATA_W-1:0];
                lane_clip[ln] = 1'b1;
            end else if (shl < NEG_LIM) begin
                lane_res[ln]  = NEG_LIM[DATA_W-1:0];
                lane_clip[ln] = 1'b1;
            end else begin
                lane_res[ln] = shl[DATA_W-1:0];
            end
        end
    end

    assign pair_clip = in_valid && (|lane_clip);

    // Purpose: register the shifted pair and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_lane  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_lane <= lane_res;
            end
        end
    end

endmodule

// File: rtl/agc_frame_stats.sv
`timescale 1ns/1ps
// agc_frame_stats: accumulates the pre-gain peak magnitude and the count of
// clipped pairs over a frame, latches them at frame end and clears.
// Assumes a sample that arrives together with the frame end belongs to the
// closing frame.  Exposes the closing-frame values for the gain loop.
module agc_frame_stats
    import agc_pkg::*;
#(
    parameter int unsigned DATA_W = SAMPLE_W,
    parameter int unsigned SW     = STAT_W,
    parameter int unsigned NLANE  = LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_frame_end,
    input  logic [NLANE-1:0][DATA_W-1:0]  in_lane,
    input  logic                          pair_clip,
    output logic                          stat_valid,
    output logic [SW-1:0]                 stat_peak,
    output logic [SW-1:0]                 stat_sat,
    output logic [SW-1:0]                 close_peak,
    output logic                          close_clipped
);

    localparam int unsigned MAG_W   = DATA_W - 1;
    localparam logic [MAG_W-1:0] MAG_MAX = '1;
    localparam logic [SW-1:0]    CNT_MAX = '1;

    logic [NLANE-1:0][MAG_W-1:0] lane_mag;
    logic [MAG_W-1:0] pair_mag;
    logic [MAG_W-1:0] peak_acc, peak_next;
    logic [SW-1:0]    sat_acc, sat_next;

    // Per-lane magnitude with the most negative value folded to the maximum.
    for (genvar ln = 0; ln < NLANE; ln++) begin : g_mag
        logic [DATA_W-1:0] neg;
        assign neg = -in_lane[ln];
        // Purpose: absolute value without wrap.
        always_comb begin
            if (in_lane[ln] == {1'b1, {(DATA_W-1){1'b0}}}) begin
                lane_mag[ln] = MAG_MAX;
            end else if (in_lane[ln][DATA_W-1]) begin
                lane_mag[ln] = neg[MAG_W-1:0];
            end else begin
                lane_mag[ln] = in_lane[ln][MAG_W-1:0];
            end
        end
    end

    // Purpose: largest magnitude over all lanes of the presented pair.
    always_comb begin
        pair_mag = '0;
        for (int k = 0; k < NLANE; k++) begin
            if (lane_mag[k] > pair_mag) begin
                pair_mag = lane_mag[k];
            end
        end
    end

    // Purpose: fold the current sample into running peak and clip count.
    always_comb begin
        peak_next = peak_acc;
        sat_next  = sat_acc;
        if (in_valid && (pair_mag > peak_acc)) begin
            peak_next = pair_mag;
        end
        if (pair_clip && (sat_acc != CNT_MAX)) begin
            sat_next = sat_acc + 1'b1;
        end
    end

    assign close_peak    = peak_next[MAG_W-1 -: SW];
    assign close_clipped = (sat_next != '0);

    // Purpose: accumulate, and on frame end publish and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_acc   <= '0;
            sat_acc    <= '0;
            stat_valid <= 1'b0;
            stat_peak  <= '0;
            stat_sat   <= '0;
        end else if (in_frame_end) begin
            peak_acc   <= '0;
            sat_acc    <= '0;
            stat_valid <= 1'b1;
            stat_peak  <= close_peak;
            stat_sat   <= sat_next;
        end else begin
            peak_acc   <= peak_next;
            sat_acc    <= sat_next;
            stat_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/agc_gain_ctrl.sv
`timescale 1ns/1ps
// agc_gain_ctrl: holds the signed gain and the holdoff counter and moves
// the gain at frame boundaries by the attack/decay/holdoff rules.
// Assumes configuration inputs are quasi-static.  An enable rise resets
// the loop and wins over a coincident frame end.
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int unsigned CW = CODE_W,
    parameter int unsigned PW = STEP_W,
    parameter int unsigned SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic [SW-1:0] cfg_target,
    input  logic [PW-1:0] cfg_attack,
    input  logic [PW-1:0] cfg_decay,
    input  logic [PW-1:0] cfg_holdoff,
    input  logic          frame_end,
    input  logic          frame_clipped,
    input  logic [SW-1:0] frame_peak,
    output logic [CW-1:0] gain_code
);

    localparam int unsigned SUM_W = ((CW > PW) ? CW : PW) + 2;
    localparam int          GMAX  = (1 << (CW - 1)) - 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(GMAX);
    localparam logic signed [SUM_W-1:0] LO = -SUM_W'(GMAX);

    logic signed [CW-1:0]    gain_q;
    logic [PW-1:0]           hold_q;
    logic                    en_q;
    logic signed [SUM_W-1:0] gain_ext, dn_raw, up_raw;
    logic signed [CW-1:0]    gain_dn, gain_up;
    logic                    enable_rise;

    // Purpose: form both stepped gains and clamp them to the legal range.
    always_comb begin
        gain_ext = SUM_W'(gain_q);
        dn_raw   = gain_ext - $signed({2'b00, cfg_attack});
        up_raw   = gain_ext + $signed({2'b00, cfg_decay});
        if (dn_raw < LO) gain_dn = CW'(LO);
        else             gain_dn = CW'(dn_raw);
        if (up_raw > HI) gain_up = CW'(HI);
        else             gain_up = CW'(up_raw);
    end

    assign enable_rise = cfg_enable && !en_q;

    // Purpose: loop state update on enable rise or frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
            hold_q <= '0;
            en_q   <= 1'b0;
        end else begin
            en_q <= cfg_enable;
            if (enable_rise) begin
                gain_q <= '0;
                hold_q <= cfg_holdoff;
            end else if (cfg_enable && frame_end) begin
                if (frame_clipped) begin
                    gain_q <= gain_dn;
                    hold_q <= cfg_holdoff;
                end else if (frame_peak < cfg_target) begin
                    if (hold_q == '0) begin
                        gain_q <= gain_up;
                    end else begin
                        hold_q <= hold_q - 1'b1;
                    end
                end else begin
                    hold_q <= cfg_holdoff;
                end
            end
        end
    end

    assign gain_code = gain_to_code(gain_q);

endmodule

// File: rtl/iq_agc.sv
`timescale 1ns/1ps
// iq_agc: frame-based digital AGC for a streamed I/Q pair.  Wires the
// saturating shifter, the per-frame statistics and the gain loop.
// Assumes frame ends are single-cycle strobes.
module iq_agc
    import agc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_frame_end,
    input  logic [SAMPLE_W-1:0]  in_i,
    input  logic [SAMPLE_W-1:0]  in_q,
    input  logic                 cfg_enable,
    input  logic [STAT_W-1:0]    cfg_target,
    input  logic [STEP_W-1:0]    cfg_attack,
    input  logic [STEP_W-1:0]    cfg_decay,
    input  logic [STEP_W-1:0]    cfg_holdoff,
    output logic                 out_valid,
    output logic [SAMPLE_W-1:0]  out_i,
    output logic [SAMPLE_W-1:0]  out_q,
    output logic [CODE_W-1:0]    gain_code,
    output logic                 stat_valid,
    output logic [STAT_W-1:0]    stat_peak,
    output logic [STAT_W-1:0]    stat_sat
);

    logic [LANES-1:0][SAMPLE_W-1:0] lane_in, lane_out;
    logic                pair_clip;
    logic [STAT_W-1:0]   close_peak;
    logic                close_clipped;

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;
    assign out_i      = lane_out[0];
    assign out_q      = lane_out[1];

    agc_shifter #(.DATA_W(SAMPLE_W), .CW(CODE_W), .NLANE(LANES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_lane   (lane_in),
        .code      (gain_code),
        .out_valid (out_valid),
        .out_lane  (lane_out),
        .pair_clip (pair_clip)
    );

    agc_frame_stats #(.DATA_W(SAMPLE_W), .SW(STAT_W), .NLANE(LANES)) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_frame_end  (in_frame_end),
        .in_lane       (lane_in),
        .pair_clip     (pair_clip),
        .stat_valid    (stat_valid),
        .stat_peak     (stat_peak),
        .stat_sat      (stat_sat),
        .close_peak    (close_peak),
        .close_clipped (close_clipped)
    );

    agc_gain_ctrl #(.CW(CODE_W), .PW(STEP_W), .SW(STAT_W)) u_loop (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable    (cfg_enable),
        .cfg_target    (cfg_target),
        .cfg_attack    (cfg_attack),
        .cfg_decay     (cfg_decay),
        .cfg_holdoff   (cfg_holdoff),
        .frame_end     (in_frame_end),
        .frame_clipped (close_clipped),
        .frame_peak    (close_peak),
        .gain_code     (gain_code)
    );

endmodule

// File: rtl/agc_checker.sv
`timescale 1ns/1ps
// agc_checker: temporal properties of iq_agc, observed at its ports.
module agc_checker
    import agc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_frame_end,
    input  logic [SAMPLE_W-1:0]  in_i,
    input  logic [SAMPLE_W-1:0]  in_q,
    input  logic                 cfg_enable,
    input  logic [CODE_W-1:0]    gain_code,
    input  logic                 out_valid,
    input  logic [SAMPLE_W-1:0]  out_i,
    input  logic                 stat_valid
);

    logic en_seen;

    // Purpose: remember the enable level seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_seen <= 1'b0;
        else        en_seen <= cfg_enable;
    end

    assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain_code == '0) |=> (out_i == $past(in_i)));

    assert_status_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_end |=> stat_valid);

    assert_status_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame_end |=> !stat_valid);

    assert_enable_rise_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !en_seen) |=> (gain_code == '0));

    assert_frozen_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> $stable(gain_code));

    assert_gain_only_at_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame_end && !(cfg_enable && !en_seen)) |=> $stable(gain_code));

    assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

endmodule

bind iq_agc agc_checker u_chk (.*);

// File: tb/sim_iq_agc.sv
`timescale 1ns/1ps
module sim_iq_agc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_frame_end = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        cfg_enable = 1'b0;
    logic [7:0]  cfg_target = 8'd200;
    logic [3:0]  cfg_attack = 4'd2;
    logic [3:0]  cfg_decay = 4'd1;
    logic [3:0]  cfg_holdoff = 4'd2;
    logic        out_valid;
    logic [15:0] out_i, out_q;
    logic [3:0]  gain_code;
    logic        stat_valid;
    logic [7:0]  stat_peak, stat_sat;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    iq_agc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame_end(in_frame_end),
        .in_i(in_i), .in_q(in_q), .cfg_enable(cfg_enable), .cfg_target(cfg_target),
        .cfg_attack(cfg_attack), .cfg_decay(cfg_decay), .cfg_holdoff(cfg_holdoff),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .gain_code(gain_code),
        .stat_valid(stat_valid), .stat_peak(stat_peak), .stat_sat(stat_sat)
    );

    // Frame table: config fixed at target 200, attack 2, decay 1, holdoff 2.
    localparam int NT = 8;
    localparam int T_I    [NT] = '{100, 100, 100, 1000, 20000, -32768, 300, 0};
    localparam int T_Q    [NT] = '{-50, -50, -50, 20, -3, 0, -30000, 0};
    localparam int T_N    [NT] = '{4, 4, 4, 3, 5, 2, 1, 0};
    localparam int T_PEAK [NT] = '{0, 0, 0, 7, 156, 255, 234, 0};
    localparam int T_SAT  [NT] = '{0, 0, 0, 0, 5, 0, 0, 0};
    localparam int T_CODE [NT] = '{0, 0, 1, 2, 0, 0, 0, 0};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sh_ref(input int x, input int code);
        int amt;
        int v;
        amt = code & 7;
        if ((code & 8) != 0) return x >>> amt;
        v = x * (1 << amt);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic send(input int i, input int q, input bit last, input int code);
        @(negedge clk);
        in_valid = 1'b1; in_frame_end = last;
        in_i = i[15:0]; in_q = q[15:0];
        @(negedge clk);
        in_valid = 1'b0; in_frame_end = 1'b0;
        chk("R12 out_valid", int'(out_valid), 1);
        chk("R1/R2 out_i", int'($signed(out_i)), sh_ref(i, code));
        chk("R1/R2 out_q", int'($signed(out_q)), sh_ref(q, code));
    endtask

    task automatic frame(input int i, input int q, input int n, input int code,
                         input int ep, input int es, input int ec, input string tag);
        if (n == 0) begin
            @(negedge clk); in_frame_end = 1'b1;
            @(negedge clk); in_frame_end = 1'b0;
        end else begin
            for (int k = 0; k < n; k++) send(i, q, (k == n - 1), code);
        end
        chk({tag, " R6 stat_valid"}, int'(stat_valid), 1);
        chk({tag, " R5 stat_peak"}, int'(stat_peak), ep);
        chk({tag, " R4 stat_sat"}, int'(stat_sat), es);
        chk({tag, " gain_code"}, int'(gain_code), ec);
    endtask

    initial begin
        #(100000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 out_valid", int'(out_valid), 0);
        chk("R13 stat_valid", int'(stat_valid), 0);
        chk("R13 gain_code", int'(gain_code), 0);
        chk("R13 stat_peak", int'(stat_peak), 0);
        chk("R13 stat_sat", int'(stat_sat), 0);

        cfg_enable = 1'b1;
        @(negedge clk);
        chk("R10 enable rise", int'(gain_code), 0);

        // Table walk: R8 holdoff/decay, R7 attack, R9 hold, R5 peak, R6 empty frame.
        cur = 0;
        for (int t = 0; t < NT; t++) begin
            frame(T_I[t], T_Q[t], T_N[t], cur, T_PEAK[t], T_SAT[t], T_CODE[t],
                  $sformatf("table%0d R7/R8/R9", t));
            cur = T_CODE[t];
        end

        // R8 countdown then R3 upper clamp with a large decay step.
        cfg_decay = 4'd15;
        frame(5, 5, 1, 0, 0, 0, 0, "R8 holdoff countdown");
        frame(5, 5, 1, 0, 0, 0, 7, "R3 clamp high");
        @(negedge clk);
        chk("R6 pulse ends", int'(stat_valid), 0);

        // R4 count cap at max gain, then R3 lower clamp (code 4'b1111).
        cfg_attack = 4'd15;
        frame(100, -300, 300, 7, 2, 255, 15, "R4 cap R3 clamp low");

        // R1 attenuation floors toward minus infinity.
        frame(-1000, 1000, 1, 15, 7, 0, 15, "R1 attenuate");
        frame(-1, 1, 1, 15, 0, 0, 15, "R1 attenuate small");

        // R11 loop disabled: gain frozen and still applied.
        cfg_enable = 1'b0;
        cfg_decay = 4'd1;
        frame(5, 5, 2, 15, 0, 0, 15, "R11 frozen");
        frame(-1000, 3, 1, 15, 7, 0, 15, "R11 still applied");

        // R10 re-enable: gain to zero, holdoff reloaded.
        @(negedge clk);
        cfg_enable = 1'b1;
        @(negedge clk);
        chk("R10 re-enable gain", int'(gain_code), 0);
        frame(5, 5, 1, 0, 0, 0, 0, "R10 holdoff load a");
        frame(5, 5, 1, 0, 0, 0, 0, "R10 holdoff load b");
        frame(5, 5, 1, 0, 0, 0, 1, "R10 holdoff load c");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule